// File: doc/BRIEF.md
# Supervisory Control Register with Write-Lock Gating

This block keeps a small supervisory control register and judges every decoded write request that reaches it. A request targets one of three places: a 256-byte nonvolatile array, the wiper registers of a set of digital potentiometers, or the control register itself. Two lock bits in the register protect the top quarter, the top half or all of the array, and they also freeze the wipers. A write-protect pin overrides the lock bits and blocks every array and wiper write.

Each request yields a one-cycle grant or abort pulse. Downstream storage commits data only on grant, so an aborted write leaves its target unchanged. The register also holds two volatile fail-status flags. A flag can be set only while its matching voltage-fail input is high, and it drops as soon as that input goes low.

The nonvolatile fields load from reset-default inputs, which stand in for storage that keeps its last value across power cycles. A saturating abort count is provided as a status output.

Top module: `sup_ctl_gate`

## Requirements
- R1: While reset is asserted and after it is released, grant, abort, both flags and the abort count are 0. lock_bits and dly_sel hold the values present on boot_lock and boot_dly.
- R2: An array request (req_kind=0) is protected when its address is in the locked region. lock_bits 00 protects nothing, 01 protects C0h-FFh, 10 protects 80h-FFh, and 11 protects 00h-FFh. A protected array write is aborted.
- R3: One cycle after a request with req_valid high, exactly one of grant or abort is high for one cycle. Neither is high without a request. A req_kind of 3 is always aborted.
- R4: A wiper request (req_kind=1) is granted only when lock_bits is 00. Any other lock setting aborts it.
- R5: While wp_in is high, every array and wiper request is aborted, whatever the lock bits are. Control-register writes are not affected by wp_in.
- R6: A control request (req_kind=2) is granted only when req_dev is A4h (1010 0 1 0 with R/W=0) and req_addr is FFh. Otherwise it is aborted and the register does not change. On grant, req_data[1:0] loads lock_bits and req_data[3:2] loads dly_sel; bits 7:6 are ignored.
- R7: A granted control write with req_data[4] (flag_a) or req_data[5] (flag_b) set sets that flag only when the matching fail input is high. When the fail input is low, the flag stays 0 and the other fields still update.
- R8: A set flag clears one cycle after its fail input is low, and it clears on reset. Writing 0 to a flag bit does not clear it.
- R9: abort_cnt increments by one with each abort pulse and saturates at its all-ones value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset (power cycle) |
| wp_in | input | 1 | Write-protect pin, high blocks array and wiper writes |
| fail_a | input | 1 | First voltage-fail input |
| fail_b | input | 1 | Second voltage-fail input |
| boot_lock | input | 2 | Reset-default value of the lock bits |
| boot_dly | input | 2 | Reset-default value of the delay select |
| req_valid | input | 1 | Request strobe, one cycle per request |
| req_kind | input | 2 | 0 array, 1 wiper, 2 control register, 3 invalid |
| req_dev | input | 8 | Slave address byte including R/W |
| req_addr | input | ADDR_W | Array address or address byte |
| req_data | input | 8 | Data byte |
| grant | output | 1 | Write permitted (one-cycle pulse) |
| abort | output | 1 | Write refused (one-cycle pulse) |
| lock_bits | output | 2 | Current lock field |
| dly_sel | output | 2 | Current power-on delay select |
| flag_a | output | 1 | First fail-status flag |
| flag_b | output | 1 | Second fail-status flag |
| abort_cnt | output | CNT_W | Saturating abort count |

## Verification
The bench builds the block with ADDR_W=8, so every lock boundary address (7Fh/80h, BFh/C0h, 00h, FFh) can be reached directly. It sets CNT_W=3, so the abort count saturates at 7 after a handful of refused writes and the saturation behaviour becomes observable inside a short run. A second reset with a different boot_lock value shows that the persistent fields reload from their default inputs while the flags clear.

// File: rtl/sup_ctl_pkg.sv
package sup_ctl_pkg;
  typedef enum logic [1:0] {
    KIND_ARRAY = 2'd0,
    KIND_WIPER = 2'd1,
    KIND_CTRL  = 2'd2,
    KIND_NONE  = 2'd3
  } req_kind_t;

  localparam logic [7:0] CTRL_DEV_ID = 8'hA4;
  localparam int         NFLAG       = 2;
  localparam int         LOCK_LSB    = 0;
  localparam int         DLY_LSB     = 2;
  localparam int         FLAG_LSB    = 4;
endpackage

// File: rtl/lock_region.sv
module lock_region #(
  parameter int ADDR_W = 8
) (
  input  logic [1:0]        lock_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o
);
  localparam int TOP = ADDR_W - 1;

  always_comb begin
    unique case (lock_i)
      2'b00:   hit_o = 1'b0;
      2'b01:   hit_o = addr_i[TOP] & addr_i[TOP-1];
      2'b10:   hit_o = addr_i[TOP];
      default: hit_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/status_flag.sv
module status_flag (
  input  logic clk,
  input  logic rst_ni,
  input  logic set_req,
  input  logic fail_in,
  output logic flag_o
);
  logic flag_q, flag_d, flag_en;

  always_comb begin
    flag_en = 1'b0;
    flag_d  = flag_q;
    if (!fail_in) begin
      flag_en = flag_q;
      flag_d  = 1'b0;
    end else if (set_req) begin
      flag_en = 1'b1;
      flag_d  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)      flag_q <= 1'b0;
    else if (flag_en) flag_q <= flag_d;
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/sat_counter.sv
module sat_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_ni,
  input  logic         inc,
  output logic [W-1:0] cnt_o
);
  localparam logic [W-1:0] TOPV = {W{1'b1}};
  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_en = inc && (cnt_q != TOPV);
    cnt_d  = cnt_q + W'(1);
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/sup_ctl_gate.sv
module sup_ctl_gate
  import sup_ctl_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wp_in,
  input  logic              fail_a,
  input  logic              fail_b,
  input  logic [1:0]        boot_lock,
  input  logic [1:0]        boot_dly,
  input  logic              req_valid,
  input  logic [1:0]        req_kind,
  input  logic [7:0]        req_dev,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [7:0]        req_data,
  output logic              grant,
  output logic              abort,
  output logic [1:0]        lock_bits,
  output logic [1:0]        dly_sel,
  output logic              flag_a,
  output logic              flag_b,
  output logic [CNT_W-1:0]  abort_cnt
);
  localparam logic [ADDR_W-1:0] CTRL_ADDR = {ADDR_W{1'b1}};

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i = rst_sync_q[1];

  req_kind_t   kind;
  logic        prot_hit;
  logic        ok_d, grant_d, abort_d, ctrl_wr;
  logic [1:0]  lock_q, lock_d, dly_q, dly_d;
  logic        grant_q, abort_q;
  logic [NFLAG-1:0] fail_vec, flag_vec;
  logic        unused_bits;

  assign kind        = req_kind_t'(req_kind);
  assign unused_bits = ^req_data[7:6];

  lock_region #(.ADDR_W(ADDR_W)) u_region (
    .lock_i (lock_q),
    .addr_i (req_addr),
    .hit_o  (prot_hit)
  );

  always_comb begin
    unique case (kind)
      KIND_ARRAY: ok_d = !wp_in && !prot_hit;
      KIND_WIPER: ok_d = !wp_in && (lock_q == 2'b00);
      KIND_CTRL:  ok_d = (req_dev == CTRL_DEV_ID) && (req_addr == CTRL_ADDR);
      default:    ok_d = 1'b0;
    endcase
    grant_d = req_valid && ok_d;
    abort_d = req_valid && !ok_d;
    ctrl_wr = grant_d && (kind == KIND_CTRL);
    lock_d  = ctrl_wr ? req_data[LOCK_LSB +: 2] : lock_q;
    dly_d   = ctrl_wr ? req_data[DLY_LSB  +: 2] : dly_q;
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      grant_q <= 1'b0;
      abort_q <= 1'b0;
      lock_q  <= boot_lock;
      dly_q   <= boot_dly;
    end else begin
      grant_q <= grant_d;
      abort_q <= abort_d;
      if (ctrl_wr) begin
        lock_q <= lock_d;
        dly_q  <= dly_d;
      end
    end
  end

  assign fail_vec = {fail_b, fail_a};

  for (genvar i = 0; i < NFLAG; i++) begin : g_flag
    status_flag u_flag (
      .clk     (clk),
      .rst_ni  (rst_i),
      .set_req (ctrl_wr && req_data[FLAG_LSB + i]),
      .fail_in (fail_vec[i]),
      .flag_o  (flag_vec[i])
    );
  end

  sat_counter #(.W(CNT_W)) u_abort_cnt (
    .clk    (clk),
    .rst_ni (rst_i),
    .inc    (abort_d),
    .cnt_o  (abort_cnt)
  );

  assign grant     = grant_q;
  assign abort     = abort_q;
  assign lock_bits = lock_q;
  assign dly_sel   = dly_q;
  assign flag_a    = flag_vec[0];
  assign flag_b    = flag_vec[1];
endmodule

// File: rtl/sup_ctl_gate_chk.sv
module sup_ctl_gate_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wp_in,
  input logic             fail_a,
  input logic             fail_b,
  input logic             req_valid,
  input logic [1:0]       req_kind,
  input logic             grant,
  input logic             abort,
  input logic [1:0]       lock_bits,
  input logic             flag_a,
  input logic             flag_b,
  input logic [CNT_W-1:0] abort_cnt
);
  localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

  // R3
  exclusive_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(grant && abort));

  // R3
  outcome_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (grant ^ abort));

  // R3
  no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !(grant || abort));

  // R5
  wp_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && wp_in && (req_kind == 2'd0 || req_kind == 2'd1)) |=> abort);

  // R4
  wiper_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_kind == 2'd1 && lock_bits != 2'b00) |=> abort);

  // R2
  full_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_kind == 2'd0 && lock_bits == 2'b11) |=> abort);

  // R6
  lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !grant |-> $stable(lock_bits));

  // R7
  flag_a_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_a) |-> $past(fail_a));

  // R7
  flag_b_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_b) |-> $past(fail_b));

  // R8
  flag_a_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fail_a |=> !flag_a);

  // R8
  flag_b_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fail_b |=> !flag_b);

  // R9
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort |-> ((abort_cnt == $past(abort_cnt) + CNT_W'(1)) ||
               ($past(abort_cnt) == CMAX && abort_cnt == CMAX)));
endmodule

bind sup_ctl_gate sup_ctl_gate_chk #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wp_in     (wp_in),
  .fail_a    (fail_a),
  .fail_b    (fail_b),
  .req_valid (req_valid),
  .req_kind  (req_kind),
  .grant     (grant),
  .abort     (abort),
  .lock_bits (lock_bits),
  .flag_a    (flag_a),
  .flag_b    (flag_b),
  .abort_cnt (abort_cnt)
);

// File: tb/sup_ctl_gate_test.sv
`timescale 1ns/1ps
module sup_ctl_gate_test;
  localparam int ADDR_W = 8;
  localparam int CNT_W  = 3;

  logic clk = 1'b0;
  logic rst_n, wp_in, fail_a, fail_b, req_valid;
  logic [1:0] boot_lock, boot_dly, req_kind;
  logic [7:0] req_dev, req_data;
  logic [ADDR_W-1:0] req_addr;
  logic grant, abort, flag_a, flag_b;
  logic [1:0] lock_bits, dly_sel;
  logic [CNT_W-1:0] abort_cnt;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  bit    exp_q[$];
  string tag_q[$];

  always #2.5 clk = ~clk;

  sup_ctl_gate #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) uut (
    .clk(clk), .rst_n(rst_n), .wp_in(wp_in), .fail_a(fail_a), .fail_b(fail_b),
    .boot_lock(boot_lock), .boot_dly(boot_dly), .req_valid(req_valid),
    .req_kind(req_kind), .req_dev(req_dev), .req_addr(req_addr),
    .req_data(req_data), .grant(grant), .abort(abort), .lock_bits(lock_bits),
    .dly_sel(dly_sel), .flag_a(flag_a), .flag_b(flag_b), .abort_cnt(abort_cnt)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: pops one expected outcome for each pulse seen
  always @(negedge clk) begin
    if (rst_n && (grant || abort)) begin
      if (exp_q.size() == 0) begin
        total++; bad++;
        $display("FAIL R3: actual=unexpected pulse expected=none");
      end else begin
        automatic bit    e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        chk({t, " grant"}, {31'd0, grant}, {31'd0, e});
        chk({t, " abort"}, {31'd0, abort}, {31'd0, !e});
      end
    end
  end

  task automatic send(logic [1:0] k, logic [7:0] dev, logic [7:0] a,
                      logic [7:0] d, bit exp_grant, string tag);
    @(negedge clk);
    req_valid = 1'b1; req_kind = k; req_dev = dev; req_addr = a; req_data = d;
    exp_q.push_back(exp_grant);
    tag_q.push_back(tag);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; wp_in = 1'b0; fail_a = 1'b0; fail_b = 1'b0;
    boot_lock = 2'b00; boot_dly = 2'b01; req_valid = 1'b0;
    req_kind = 2'd0; req_dev = 8'h00; req_addr = '0; req_data = 8'h00;
    do_reset();
    // R1 reset state
    chk("R1 grant", {31'd0, grant}, 0);
    chk("R1 abort", {31'd0, abort}, 0);
    chk("R1 lock", {30'd0, lock_bits}, 0);
    chk("R1 dly", {30'd0, dly_sel}, 1);
    chk("R1 flags", {30'd0, flag_b, flag_a}, 0);
    chk("R1 cnt", {29'd0, abort_cnt}, 0);

    send(2'd0, 8'h00, 8'hFF, 8'h11, 1, "R2 open FF");
    send(2'd1, 8'h00, 8'h00, 8'h22, 1, "R4 open wiper");
    send(2'd3, 8'h00, 8'h00, 8'h00, 0, "R3 kind3");
    send(2'd2, 8'hA4, 8'hFF, 8'h05, 1, "R6 lock01");
    chk("R6 lock01", {30'd0, lock_bits}, 1);
    send(2'd0, 8'h00, 8'hC0, 8'h00, 0, "R2 C0 q");
    send(2'd0, 8'h00, 8'hBF, 8'h00, 1, "R2 BF q");
    send(2'd0, 8'h00, 8'hFF, 8'h00, 0, "R2 FF q");
    send(2'd1, 8'h00, 8'h00, 8'h00, 0, "R4 wiper q");
    chk("R9 cnt4", {29'd0, abort_cnt}, 4);

    send(2'd2, 8'hA4, 8'hFF, 8'h06, 1, "R6 lock10");
    send(2'd0, 8'h00, 8'h80, 8'h00, 0, "R2 80 h");
    send(2'd0, 8'h00, 8'h7F, 8'h00, 1, "R2 7F h");
    send(2'd2, 8'hA4, 8'hFF, 8'h07, 1, "R6 lock11");
    send(2'd0, 8'h00, 8'h00, 8'h00, 0, "R2 00 all");

    send(2'd2, 8'hA5, 8'hFF, 8'h04, 0, "R6 bad dev");
    send(2'd2, 8'hA4, 8'hFE, 8'h04, 0, "R6 bad addr");
    chk("R6 lock kept", {30'd0, lock_bits}, 3);
    chk("R9 sat", {29'd0, abort_cnt}, 7);

    send(2'd2, 8'hA4, 8'hFF, 8'h08, 1, "R6 unlock dly");
    chk("R6 lock00", {30'd0, lock_bits}, 0);
    chk("R6 dly10", {30'd0, dly_sel}, 2);
    wp_in = 1'b1;
    send(2'd0, 8'h00, 8'h10, 8'h00, 0, "R5 array");
    send(2'd1, 8'h00, 8'h00, 8'h00, 0, "R5 wiper");
    send(2'd2, 8'hA4, 8'hFF, 8'h04, 1, "R5 ctrl ok");
    wp_in = 1'b0;
    chk("R9 held", {29'd0, abort_cnt}, 7);

    fail_a = 1'b0; fail_b = 1'b1;
    send(2'd2, 8'hA4, 8'hFF, 8'h35, 1, "R7 wr1");
    chk("R7 a stays", {31'd0, flag_a}, 0);
    chk("R7 b set", {31'd0, flag_b}, 1);
    chk("R7 lock upd", {30'd0, lock_bits}, 1);
    fail_a = 1'b1;
    send(2'd2, 8'hA4, 8'hFF, 8'h34, 1, "R7 wr2");
    chk("R7 a set", {31'd0, flag_a}, 1);
    send(2'd2, 8'hA4, 8'hFF, 8'h04, 1, "R8 wr0");
    chk("R8 zero write", {30'd0, flag_b, flag_a}, 3);
    fail_b = 1'b0;
    @(negedge clk);
    chk("R8 b clear", {31'd0, flag_b}, 0);
    chk("R8 a kept", {31'd0, flag_a}, 1);

    boot_lock = 2'b10;
    do_reset();
    chk("R8 reset flags", {30'd0, flag_b, flag_a}, 0);
    chk("R1 reload lock", {30'd0, lock_bits}, 2);
    chk("R1 reload cnt", {29'd0, abort_cnt}, 0);
    send(2'd0, 8'h00, 8'h80, 8'h00, 0, "R2 boot half");
    @(negedge clk);
    chk("R3 all seen", exp_q.size(), 0);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule